// File: doc/BRIEF.md
# Scan-chain coprocessor register access

This block is a 48-bit debug data register placed behind a test access port. It gives an external host read and write access to a small bank of 32-bit coprocessor control registers. The TAP controller outside the block supplies one-cycle capture, shift and update strobes in the system clock domain, along with the serial input. The block returns the serial output from the low end of its shift register.

An access takes two phases. First the host shifts in a request frame that carries a register address, a direction bit, write data and a set access flag, and ends that scan with an update. The block counts out a fixed completion latency and then performs the access. Meanwhile the host sends polling scans. Each polling scan captures a completion flag into the access-flag position and, for reads, the register value into the data field. The host repeats polling scans until the flag reads 1. A polling scan whose access and direction bits are both 0 acts as a no-op.

The bank holds a system control register, a translation table base, data and instruction fault status, a fault address, a debug override register and a cache debug control register. Status bits from the control, override and cache debug registers are exported as registered outputs.

Top module: `cpreg_scan`

## Requirements
- R1: The chain is exactly 48 bits. On a shift strobe it moves toward bit 0, the serial input enters bit 47, and the serial output is bit 0. A capture loads the data field into bits 31:0, the completion flag into bit 32, and zero into bits 47:33.
- R2: In a frame, bit 47 is the direction bit and bits 46:33 hold the 14-bit register address. The address is formed as {op1[2:0], op2[2:0], crn[3:0], crm[3:0]}. Registers that differ only in op1 or only in op2 are distinct.
- R3: When the block is idle, an update whose bit 32 is 1 starts an access. A direction bit of 1 writes the frame's bits 31:0 to the addressed register. A direction bit of 0 reads the addressed register.
- R4: An access completes LATENCY clocks after the update that started it. A capture samples bit 32 as 0 before completion and as 1 from then on, until the next access starts.
- R5: After a read completes, captures load the register value into bits 31:0. While an access is in flight, and after a write completes, captures load zero there.
- R6: An update whose bit 32 is 0 does nothing. It does not alter an access in flight, and when the block is idle it neither writes a register nor clears the completion flag.
- R7: An update with bit 32 set that arrives while an access is in flight is ignored. The completion time and target of the first access are unchanged.
- R8: An address outside the bank reads as zero and drops writes, and the access still completes normally.
- R9: The control register {op1 0, op2 0, crn 1, crm 0} drives three outputs: bit 0 drives the MMU enable, bit 2 drives the data cache enable, and bit 12 drives the instruction cache enable.
- R10: Bits 2:0 of the cache debug control register {op1 7, op2 0, crn 15, crm 0} drive the 3-bit cache debug output. Bit 19 of the debug override register {op1 0, op2 0, crn 15, crm 0} drives the test-and-clean output.
- R11: A synchronous reset clears the shift register, every bank register, the in-flight state and the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_i | input | 1 | Capture strobe from the TAP controller |
| shift_i | input | 1 | Shift strobe, one bit per cycle |
| upd_i | input | 1 | Update strobe; acts on the shift register contents |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (shift register bit 0) |
| mmu_en_o | output | 1 | Control register bit 0 |
| dcache_en_o | output | 1 | Control register bit 2 |
| icache_en_o | output | 1 | Control register bit 12 |
| cdbg_ctl_o | output | 3 | Cache debug control bits 2:0 |
| test_clean_o | output | 1 | Debug override bit 19 |

## Verification
The bench drives the chain with several kinds of frame: read and write requests to registers whose addresses differ only in op1 or only in op2, no-op frames sent both during an access and while idle, requests to unmapped addresses, and raw shift streams with no capture. The raw streams check the chain length and bit order. The paired addresses check the address packing. Short captures taken one clock before and one clock at the expected completion pin the latency exactly. A repeated update during an access shows whether a busy request is ignored or wrongly restarts the counter.

// File: rtl/cpscan_pkg.sv
package cpscan_pkg;

  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 14;
  localparam int CHAIN_W = DATA_W + 1 + ADDR_W + 1;
  localparam int NREG    = 7;

  // Frame in chain order: bit 0 is shifted first
  typedef struct packed {
    logic              rw;
    logic [ADDR_W-1:0] addr;
    logic              acc;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [ADDR_W-1:0] pack_addr(input int op1, input int op2,
                                                  input int crn, input int crm);
    logic [ADDR_W-1:0] a;
    a[13:11] = 3'(op1);
    a[10:8]  = 3'(op2);
    a[7:4]   = 4'(crn);
    a[3:0]   = 4'(crm);
    return a;
  endfunction

  localparam int IDX_CTRL = 0;
  localparam int IDX_TTB  = 1;
  localparam int IDX_DFS  = 2;
  localparam int IDX_IFS  = 3;
  localparam int IDX_FAR  = 4;
  localparam int IDX_OVR  = 5;
  localparam int IDX_CDBG = 6;

  function automatic logic [ADDR_W-1:0] reg_addr(input int idx);
    case (idx)
      IDX_CTRL: return pack_addr(0, 0, 1, 0);
      IDX_TTB:  return pack_addr(0, 0, 2, 0);
      IDX_DFS:  return pack_addr(0, 0, 5, 0);
      IDX_IFS:  return pack_addr(0, 1, 5, 0);
      IDX_FAR:  return pack_addr(0, 0, 6, 0);
      IDX_OVR:  return pack_addr(0, 0, 15, 0);
      default:  return pack_addr(7, 0, 15, 0);
    endcase
  endfunction

endpackage

// File: rtl/cpscan_shift.sv
module cpscan_shift #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         shift,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic         tdo,
  output logic [W-1:0] sr_o
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (cap)   sr <= cap_val;
    else if (shift) sr <= {tdi, sr[W-1:1]};
  end

  assign tdo  = sr[0];
  assign sr_o = sr;

  // R1: a shift moves every bit one place toward the output
  p_shift_moves_r1: assert property (@(posedge clk) disable iff (rst)
    shift && !cap |=> sr[W-2:0] == $past(sr[W-1:1]) && sr[W-1] == $past(tdi));

  // R1: a capture loads the presented frame
  p_capture_loads_r1: assert property (@(posedge clk) disable iff (rst)
    cap |=> sr == $past(cap_val));

endmodule

// File: rtl/cpscan_txn.sv
module cpscan_txn
  import cpscan_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  frame_t            frame,
  input  logic [DATA_W-1:0] rd_val,
  output logic              wr_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);

  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam int KW = $clog2(LATENCY + 1) + 1;

  logic [CW-1:0]     cnt;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              start;
  logic              finish;

  assign start  = upd && frame.acc && !busy;
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ready  <= 1'b0;
      cnt    <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      ready  <= 1'b0;
      cnt    <= CW'(LATENCY - 1);
      rw_q   <= frame.rw;
      addr_q <= frame.addr;
      data_q <= frame.data;
      rdata  <= '0;
    end else if (finish) begin
      busy  <= 1'b0;
      ready <= 1'b1;
      if (!rw_q) rdata <= rd_val;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign wr_en    = finish && rw_q;
  assign acc_addr = addr_q;
  assign wr_data  = data_q;

  // Checker-side cycle counter for the completion window
  logic [KW-1:0] lat_k;
  always_ff @(posedge clk) begin
    if (rst)        lat_k <= '0;
    else if (start) lat_k <= '0;
    else if (busy)  lat_k <= lat_k + 1'b1;
  end

  // R4: completion flag rises exactly LATENCY clocks after the start
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> lat_k == KW'(LATENCY));

  // R3: an accepted request enters the busy state with the flag cleared
  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    upd && frame.acc && !busy |=> busy && !ready);

  // R7: updates while busy leave the latched request untouched
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy && upd && !finish |=> $stable(addr_q) && $stable(rw_q) && $stable(data_q) && busy);

  // R6: an update without the access flag when idle changes nothing
  p_noop_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy && upd && !frame.acc |=> !busy && $stable(ready) && $stable(rdata));

endmodule

// File: rtl/cpscan_bank.sv
module cpscan_bank
  import cpscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] ovr_o,
  output logic [DATA_W-1:0] cdbg_o
);

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic                        hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = reg_addr(g);
    always_ff @(posedge clk) begin
      if (rst)                         regs[g] <= '0;
      else if (we && addr == MY_ADDR)  regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    hit   = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == reg_addr(i)) begin
        rdata = regs[i];
        hit   = 1'b1;
      end
    end
  end

  assign ctrl_o = regs[IDX_CTRL];
  assign ovr_o  = regs[IDX_OVR];
  assign cdbg_o = regs[IDX_CDBG];

  // R8: a write to an unmapped address changes no register
  p_unmapped_drop_r8: assert property (@(posedge clk) disable iff (rst)
    we && !hit |=> $stable(regs));

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !hit |-> rdata == '0);

endmodule

// File: rtl/cpreg_scan.sv
module cpreg_scan
  import cpscan_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_i,
  input  logic       shift_i,
  input  logic       upd_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  output logic       mmu_en_o,
  output logic       dcache_en_o,
  output logic       icache_en_o,
  output logic [2:0] cdbg_ctl_o,
  output logic       test_clean_o
);

  logic [CHAIN_W-1:0] sr;
  frame_t             cap_frame;
  logic               ready, busy, wr_en;
  logic [ADDR_W-1:0]  acc_addr;
  logic [DATA_W-1:0]  wr_data, rd_val, rdata;
  logic [DATA_W-1:0]  ctrl, ovr, cdbg;

  always_comb begin
    cap_frame      = '0;
    cap_frame.acc  = ready;
    cap_frame.data = rdata;
  end

  cpscan_shift #(.W(CHAIN_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap_i),
    .shift   (shift_i),
    .cap_val (cap_frame),
    .tdi     (tdi_i),
    .tdo     (tdo_o),
    .sr_o    (sr)
  );

  cpscan_txn #(.LATENCY(LATENCY)) u_txn (
    .clk      (clk),
    .rst      (rst),
    .upd      (upd_i),
    .frame    (frame_t'(sr)),
    .rd_val   (rd_val),
    .wr_en    (wr_en),
    .acc_addr (acc_addr),
    .wr_data  (wr_data),
    .ready    (ready),
    .busy     (busy),
    .rdata    (rdata)
  );

  cpscan_bank u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .addr   (acc_addr),
    .wdata  (wr_data),
    .rdata  (rd_val),
    .ctrl_o (ctrl),
    .ovr_o  (ovr),
    .cdbg_o (cdbg)
  );

  assign mmu_en_o     = ctrl[0];
  assign dcache_en_o  = ctrl[2];
  assign icache_en_o  = ctrl[12];
  assign cdbg_ctl_o   = cdbg[2:0];
  assign test_clean_o = ovr[19];

  // R5: data captured while busy is zero
  p_busy_data_zero_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> rdata == '0);

  // R11: reset leaves the block idle with the flag clear
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> !busy && !ready && sr == '0);

endmodule

// File: tb/cpreg_scan_bench.sv
module cpreg_scan_bench;

  localparam int LAT = 80;

  logic clk = 1'b0;
  logic rst, cap, shift, upd, tdi;
  logic tdo, mmu_en, dc_en, ic_en, tclean;
  logic [2:0] cdbg;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpreg_scan #(.LATENCY(LAT)) u_cpreg_scan (
    .clk(clk), .rst(rst), .cap_i(cap), .shift_i(shift), .upd_i(upd), .tdi_i(tdi),
    .tdo_o(tdo), .mmu_en_o(mmu_en), .dcache_en_o(dc_en), .icache_en_o(ic_en),
    .cdbg_ctl_o(cdbg), .test_clean_o(tclean)
  );

  // register addresses {op1, op2, crn, crm}
  localparam logic [13:0] A_CTRL = {3'd0, 3'd0, 4'd1, 4'd0};
  localparam logic [13:0] A_TTB  = {3'd0, 3'd0, 4'd2, 4'd0};
  localparam logic [13:0] A_DFS  = {3'd0, 3'd0, 4'd5, 4'd0};
  localparam logic [13:0] A_IFS  = {3'd0, 3'd1, 4'd5, 4'd0};
  localparam logic [13:0] A_OVR  = {3'd0, 3'd0, 4'd15, 4'd0};
  localparam logic [13:0] A_CDBG = {3'd7, 3'd0, 4'd15, 4'd0};
  localparam logic [13:0] A_NONE = {3'd2, 3'd3, 4'd9, 4'd4};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture, shift 48 bits, optional update; ends at the negedge after the update edge
  task automatic scan(input logic [47:0] din, output logic [47:0] dout, input bit do_upd);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    for (int i = 0; i < 48; i++) begin
      dout[i] = tdo;
      tdi     = din[i];
      shift   = 1'b1;
      @(negedge clk);
    end
    shift = 1'b0;
    if (do_upd) begin
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
    end
  endtask

  task automatic shift_only(input logic [47:0] din, output logic [47:0] dout);
    for (int i = 0; i < 48; i++) begin
      dout[i] = tdo;
      tdi     = din[i];
      shift   = 1'b1;
      @(negedge clk);
    end
    shift = 1'b0;
  endtask

  // capture at the k-th rising edge from now, then shift up to the flag position
  task automatic peek(input int k, output logic flag);
    repeat (k - 1) @(negedge clk);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    shift = 1'b1;
    repeat (32) @(negedge clk);
    shift = 1'b0;
    flag = tdo;
  endtask

  task automatic access(input logic rw, input logic [13:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ok, output logic [47:0] last);
    logic [47:0] d;
    scan({rw, a, 1'b1, wd}, d, 1'b1);
    ok = 1'b0;
    for (int n = 0; n < 6; n++) begin
      scan(48'h0, d, 1'b1);
      if (d[32]) begin
        ok = 1'b1;
        break;
      end
    end
    rd   = d[31:0];
    last = d;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] v, input string req);
    logic [31:0] rd; logic ok; logic [47:0] l;
    access(1'b1, a, v, rd, ok, l);
    check(ok, req, 64'(ok), 64'd1);
  endtask

  task automatic rd_expect(input logic [13:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic ok; logic [47:0] l;
    access(1'b0, a, 32'h0, rd, ok, l);
    check(ok && rd == exp, req, {31'(0), ok, rd}, {32'd1, exp});
  endtask

  task automatic drain();
    repeat (LAT + 5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [47:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    scan(48'h0, d, 1'b0);
    check(d == 48'h0, "R11 reset capture", 64'(d), 64'h0);
    check({mmu_en, dc_en, ic_en, cdbg, tclean} == 7'h0, "R11 reset outputs",
          64'({mmu_en, dc_en, ic_en, cdbg, tclean}), 64'h0);
  endtask

  task automatic t_chain();
    logic [47:0] d;
    shift_only(48'hA5C3_1E7F_9B24, d);
    shift_only(48'h0, d);
    check(d == 48'hA5C3_1E7F_9B24, "R1 chain length and order", 64'(d), 64'hA5C3_1E7F_9B24);
  endtask

  task automatic t_readwrite();
    logic [31:0] rd; logic ok; logic [47:0] l;
    wr(A_TTB, 32'hCAFE_0000, "R3 write ttb");
    access(1'b0, A_TTB, 32'h0, rd, ok, l);
    check(ok && rd == 32'hCAFE_0000, "R3 R5 read ttb", 64'(rd), 64'hCAFE_0000);
    check(l[47:33] == 15'h0, "R1 capture upper zero", 64'(l[47:33]), 64'h0);
    access(1'b1, A_TTB, 32'h1234_5678, rd, ok, l);
    check(ok && rd == 32'h0, "R5 data zero after write", 64'(rd), 64'h0);
    rd_expect(A_TTB, 32'h1234_5678, "R3 read back overwrite");
  endtask

  task automatic t_decode();
    wr(A_DFS, 32'h0000_00D5, "R2 write dfs");
    wr(A_IFS, 32'h0000_01F5, "R2 write ifs");
    rd_expect(A_DFS, 32'h0000_00D5, "R2 op2 distinct dfs");
    rd_expect(A_IFS, 32'h0000_01F5, "R2 op2 distinct ifs");
    wr(A_OVR, 32'h0008_0000, "R2 write ovr");
    wr(A_CDBG, 32'h0000_0005, "R2 write cdbg");
    rd_expect(A_OVR, 32'h0008_0000, "R2 op1 distinct ovr");
    rd_expect(A_CDBG, 32'h0000_0005, "R2 op1 distinct cdbg");
  endtask

  task automatic t_latency();
    logic [47:0] d; logic f;
    scan({1'b0, A_TTB, 1'b1, 32'h0}, d, 1'b1);
    peek(LAT, f);
    check(f == 1'b0, "R4 busy one clock before completion", 64'(f), 64'h0);
    drain();
    scan({1'b0, A_TTB, 1'b1, 32'h0}, d, 1'b1);
    peek(LAT + 1, f);
    check(f == 1'b1, "R4 ready at completion", 64'(f), 64'h1);
    drain();
  endtask

  task automatic t_busy_ignore();
    logic [47:0] d; logic f;
    scan({1'b1, A_FAR_addr(), 1'b1, 32'h0000_0FA0}, d, 1'b1);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    peek(LAT, f);
    check(f == 1'b1, "R7 repeated request does not restart", 64'(f), 64'h1);
    drain();
    rd_expect(A_FAR_addr(), 32'h0000_0FA0, "R7 first request committed");
  endtask

  function automatic logic [13:0] A_FAR_addr();
    return {3'd0, 3'd0, 4'd6, 4'd0};
  endfunction

  task automatic t_noop();
    logic [47:0] d; logic [31:0] rd; logic ok; logic f;
    wr(A_CTRL, 32'h0000_0001, "R6 setup ctrl");
    scan({1'b1, A_CTRL, 1'b1, 32'h0000_1004}, d, 1'b1);
    scan({1'b0, A_CTRL, 1'b0, 32'hFFFF_FFFF}, d, 1'b1);
    check(d[32] == 1'b0, "R4 busy on first poll", 64'(d[32]), 64'h0);
    for (int n = 0; n < 6; n++) begin
      scan(48'h0, d, 1'b1);
      if (d[32]) break;
    end
    check(d[32] == 1'b1, "R6 in-flight write completes", 64'(d[32]), 64'h1);
    rd_expect(A_CTRL, 32'h0000_1004, "R6 no-op left write intact");
    // idle no-op with direction set and data present
    scan({1'b1, A_CTRL, 1'b0, 32'h0000_0FFF}, d, 1'b1);
    peek(2, f);
    check(f == 1'b1, "R6 idle no-op keeps flag", 64'(f), 64'h1);
    rd_expect(A_CTRL, 32'h0000_1004, "R6 idle no-op writes nothing");
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; logic ok; logic [47:0] l;
    access(1'b1, A_NONE, 32'hDEAD_BEEF, rd, ok, l);
    check(ok, "R8 unmapped write completes", 64'(ok), 64'h1);
    access(1'b0, A_NONE, 32'h0, rd, ok, l);
    check(ok && rd == 32'h0, "R8 unmapped read zero", 64'(rd), 64'h0);
  endtask

  task automatic t_status();
    wr(A_CTRL, 32'h0000_1005, "R9 write ctrl");
    check({mmu_en, dc_en, ic_en} == 3'b111, "R9 status all set",
          64'({mmu_en, dc_en, ic_en}), 64'h7);
    wr(A_CTRL, 32'h0000_0004, "R9 write ctrl dcache only");
    check({mmu_en, dc_en, ic_en} == 3'b010, "R9 status dcache only",
          64'({mmu_en, dc_en, ic_en}), 64'h2);
    wr(A_CDBG, 32'hFFFF_FFF6, "R10 write cdbg");
    wr(A_OVR, 32'h0008_0000, "R10 write ovr");
    check(cdbg == 3'b110 && tclean == 1'b1, "R10 cache debug outputs",
          64'({cdbg, tclean}), 64'hD);
    wr(A_OVR, 32'hFFF7_FFFF, "R10 clear bit 19");
    check(tclean == 1'b0, "R10 test-and-clean cleared", 64'(tclean), 64'h0);
  endtask

  task automatic t_reset_mid();
    logic [47:0] d;
    wr(A_CTRL, 32'h0000_1005, "R11 setup");
    scan({1'b1, A_TTB, 1'b1, 32'h5555_5555}, d, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({mmu_en, dc_en, ic_en} == 3'b000, "R11 reset clears ctrl",
          64'({mmu_en, dc_en, ic_en}), 64'h0);
    scan(48'h0, d, 1'b0);
    check(d == 48'h0, "R11 reset clears flag and data", 64'(d), 64'h0);
    drain();
    rd_expect(A_TTB, 32'h0, "R11 aborted write not committed");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cap = 1'b0; shift = 1'b0; upd = 1'b0; tdi = 1'b0;
    @(negedge clk);
    t_reset();
    t_chain();
    t_readwrite();
    t_decode();
    t_latency();
    t_busy_ignore();
    t_noop();
    t_unmapped();
    t_status();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule